// File: doc/BRIEF.md
# Polyphase Decimate-by-Three FIR Filter

This block is a streaming low-pass decimator. Signed 8-bit samples arrive with a valid strobe. For every three accepted samples it emits one signed 20-bit result with a one-cycle output strobe. The result is the full nine-tap convolution of the input with a stored coefficient set, evaluated only at every third sample instant. The block never runs a full-rate filter that then throws results away. The coefficient index space is split into three polyphase branches. Each accepted sample is broadcast to all branch multipliers in the same cycle. Each branch steps through its own three coefficients as the phase advances. The branch sums are folded together in a transposed delay chain once per decimation period.

The coefficients are held in a small register set. Reset loads a fixed symmetric default, and a write port can replace any tap while the stream is idle. When the tap count is not a multiple of three, the missing taps behave as zero coefficients.

Top module: `poly_decim3_fir`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` is 0 and `out_data` is 0. Reset also restarts the sample count and reloads the coefficients h[k] = 8·(min(k, NTAPS−1−k) + 1).
- R2: Accepted samples are numbered n = 0, 1, 2, … from reset. A sample is accepted in a cycle where `in_valid` is 1. For every accepted sample with n mod 3 = 2 and n ≥ 8, `out_valid` is 1 for exactly the one cycle after the edge that accepted it. In that cycle `out_data` = Σ_{k=0..8} h[k]·x[n−k], with x of a negative index taken as 0.
- R3: No output strobe is produced for the accepted samples n = 2 and n = 5. The first strobe follows sample n = 8.
- R4: A cycle with `in_valid` low does not advance the phase, does not change any accumulator and does not raise `out_valid`. Idle gaps of any length leave the results unchanged.
- R5: A write with `cw_en` = 1 and `cw_addr` = k < NTAPS sets h[k] to the signed value on `cw_data`, starting from the next cycle. A write with `cw_addr` ≥ NTAPS changes nothing.
- R6: When NTAPS is not a multiple of 3, the filter behaves as a 9-tap filter whose taps from NTAPS to 8 are zero. With NTAPS = 7, h[7] = h[8] = 0 and writes to addresses 7 and 8 are ignored.
- R7: Full-scale operands give the exact result with no wrap. With all nine taps and inputs at −128, the output is +147456.
- R8: Between strobes `out_data` holds the value of the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DATA_W (8) | Signed input sample |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | clog2(padded taps) (4) | Coefficient index to write |
| cw_data | input | COEF_W (8) | Signed coefficient value |
| out_valid | output | 1 | One-cycle strobe for a decimated result |
| out_data | output | ACC_W (20) | Signed decimated result |

## Verification
Each result appears one cycle after the rising edge that accepts the third sample of a period. A coefficient write is in effect one cycle after its edge. The bench drives every input on a falling edge and reads the outputs on the next falling edge after the accepting rising edge. There it expects the strobe exactly when the sample count calls for one. During idle and write cycles it reads again at each falling edge to confirm that no strobe appears and that the held value does not move. A second instance with seven taps runs on the same stimulus, so the zero-padded branch is checked cycle for cycle against its own model.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    // Radix-4 recoded multiplier digit
    typedef enum logic [2:0] {
        BD_ZERO,
        BD_POS1,
        BD_POS2,
        BD_NEG1,
        BD_NEG2
    } booth_dig_e;

    // Per-cycle control word shared by all branches
    typedef struct packed {
        logic take;   // a sample is accepted this cycle
        logic first;  // it is the first sample of a period
        logic last;   // it closes a period
        logic emit;   // the closing period produces an output
    } pdec_step_t;

    function automatic booth_dig_e booth_recode(input logic [2:0] trip);
        booth_dig_e d;
        case (trip)
            3'b001, 3'b010: d = BD_POS1;
            3'b011:         d = BD_POS2;
            3'b100:         d = BD_NEG2;
            3'b101, 3'b110: d = BD_NEG1;
            default:        d = BD_ZERO;
        endcase
        return d;
    endfunction

    // Tap count rounded up to a whole number of periods
    function automatic int padded_len(input int ntaps, input int decim);
        return ((ntaps + decim - 1) / decim) * decim;
    endfunction

    // Symmetric triangular default set
    function automatic int default_coef(input int k, input int ntaps);
        int m;
        m = (k < ntaps - 1 - k) ? k : ntaps - 1 - k;
        return 8 * (m + 1);
    endfunction

endpackage

// File: rtl/pdec_booth_mul.sv
module pdec_booth_mul
    import pdec_pkg::*;
#(
    parameter int A_W = 8,
    parameter int B_W = 8
) (
    input  logic signed [A_W-1:0]     a,
    input  logic signed [B_W-1:0]     b,
    output logic signed [A_W+B_W-1:0] p
);
    localparam int ND   = (B_W + 1) / 2;
    localparam int BX_W = 2 * ND + 1;
    localparam int P_W  = A_W + B_W;

    logic signed [B_W:0]    b_sh;
    logic signed [BX_W-1:0] bx;
    logic signed [P_W-1:0]  a_ext;
    logic signed [P_W-1:0]  pp [ND];

    assign b_sh  = {b, 1'b0};
    assign bx    = BX_W'(b_sh);
    assign a_ext = P_W'(a);

    for (genvar gd = 0; gd < ND; gd++) begin : g_digit
        booth_dig_e           dg;
        logic signed [P_W-1:0] pp_g;

        assign dg = booth_recode(bx[2*gd+2 -: 3]);

        always_comb begin
            case (dg)
                BD_POS1: pp_g = a_ext;
                BD_POS2: pp_g = a_ext <<< 1;
                BD_NEG1: pp_g = -a_ext;
                BD_NEG2: pp_g = -(a_ext <<< 1);
                default: pp_g = '0;
            endcase
        end

        assign pp[gd] = pp_g <<< (2 * gd);
    end

    always_comb begin
        logic signed [P_W-1:0] sum;
        sum = '0;
        for (int d = 0; d < ND; d++) begin
            sum = sum + pp[d];
        end
        p = sum;
    end

endmodule

// File: rtl/pdec_coef_bank.sv
module pdec_coef_bank
    import pdec_pkg::*;
#(
    parameter int COEF_W = 8,
    parameter int NTAPS  = 9,
    parameter int DECIM  = 3,
    parameter int NBR    = 3,
    parameter int ADDR_W = 4,
    parameter int PH_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic signed [COEF_W-1:0] wdata,
    input  logic [PH_W-1:0]          phase,
    output logic signed [COEF_W-1:0] br_coef [NBR]
);
    logic [NTAPS-1:0][COEF_W-1:0] taps;

    always_ff @(posedge clk) begin
        for (int k = 0; k < NTAPS; k++) begin
            if (rst) begin
                taps[k] <= COEF_W'(default_coef(k, NTAPS));
            end else if (we && addr == ADDR_W'(k)) begin
                taps[k] <= wdata;
            end
        end
    end

    // Branch j at phase p reads tap DECIM*j + (DECIM-1-p); indices past NTAPS read as zero
    for (genvar j = 0; j < NBR; j++) begin : g_sel
        always_comb begin
            int idx;
            logic [COEF_W-1:0] sel;
            idx = -1;
            for (int p = 0; p < DECIM; p++) begin
                if (phase == PH_W'(p)) begin
                    idx = DECIM * j + (DECIM - 1 - p);
                end
            end
            sel = '0;
            for (int k = 0; k < NTAPS; k++) begin
                if (k == idx) begin
                    sel = taps[k];
                end
            end
            br_coef[j] = sel;
        end
    end

    // R5
    bad_addr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr >= ADDR_W'(NTAPS)) |=> $stable(taps));

endmodule

// File: rtl/pdec_branch.sv
module pdec_branch
    import pdec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  pdec_step_t               step,
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [ACC_W-1:0]  tot
);
    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  acc_q;

    pdec_booth_mul #(
        .A_W (COEF_W),
        .B_W (DATA_W)
    ) u_mul (
        .a (coef),
        .b (x),
        .p (prod)
    );

    assign prod_ext = ACC_W'(prod);
    assign tot      = (step.first ? '0 : acc_q) + prod_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (step.take) begin
            acc_q <= tot;
        end
    end

    // R2
    exact_product_chk: assert property (@(posedge clk) disable iff (rst)
        step.take |-> (prod == PROD_W'(x * coef)));

    // R4
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step.take |=> $stable(acc_q));

endmodule

// File: rtl/poly_decim3_fir.sv
module poly_decim3_fir
    import pdec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 20,
    parameter int NTAPS  = 9,
    parameter int DECIM  = 3,
    localparam int NPAD   = padded_len(NTAPS, DECIM),
    localparam int ADDR_W = $clog2(NPAD)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic                     cw_en,
    input  logic [ADDR_W-1:0]        cw_addr,
    input  logic signed [COEF_W-1:0] cw_data,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_data
);
    localparam int NBR    = NPAD / DECIM;
    localparam int PH_W   = $clog2(DECIM);
    localparam int FILL_W = $clog2(NBR) + 1;

    logic [PH_W-1:0]          ph;
    logic [FILL_W-1:0]        fill;
    pdec_step_t               step;
    logic signed [COEF_W-1:0] br_coef [NBR];
    logic signed [ACC_W-1:0]  tot     [NBR];
    logic signed [ACC_W-1:0]  chain   [NBR+1];
    logic                     ov_q;

    always_comb begin
        step.take  = in_valid;
        step.first = in_valid && (ph == '0);
        step.last  = in_valid && (ph == PH_W'(DECIM - 1));
        step.emit  = step.last && (fill == FILL_W'(NBR - 1));
    end

    // Phase within the decimation period
    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (step.take) begin
            ph <= step.last ? '0 : ph + 1'b1;
        end
    end

    // Count of closed periods until the chain holds only valid data
    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else if (step.last && fill != FILL_W'(NBR - 1)) begin
            fill <= fill + 1'b1;
        end
    end

    pdec_coef_bank #(
        .COEF_W (COEF_W),
        .NTAPS  (NTAPS),
        .DECIM  (DECIM),
        .NBR    (NBR),
        .ADDR_W (ADDR_W),
        .PH_W   (PH_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (cw_en),
        .addr    (cw_addr),
        .wdata   (cw_data),
        .phase   (ph),
        .br_coef (br_coef)
    );

    for (genvar j = 0; j < NBR; j++) begin : g_branch
        pdec_branch #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .ACC_W  (ACC_W)
        ) u_br (
            .clk  (clk),
            .rst  (rst),
            .step (step),
            .x    (in_sample),
            .coef (br_coef[j]),
            .tot  (tot[j])
        );
    end

    // Transposed chain: chain[j] collects branches j..NBR-1 from successive periods.
    // chain[NBR] stays zero; chain[0] is the output register, written only on emit.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j <= NBR; j++) begin
                chain[j] <= '0;
            end
            ov_q <= 1'b0;
        end else begin
            ov_q <= step.emit;
            if (step.last) begin
                for (int j = 0; j < NBR; j++) begin
                    if (j > 0 || step.emit) begin
                        chain[j] <= tot[j] + chain[j+1];
                    end
                end
            end
        end
    end

    assign out_valid = ov_q;
    assign out_data  = chain[0];

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0));

    // R2
    strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid) && $past(ph) == PH_W'(DECIM - 1)));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(ph));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_data));

endmodule

// File: tb/poly_decim3_fir_test.sv
module poly_decim3_fir_test;

    localparam int N_STIM = 24;
    localparam int STIM_X   [N_STIM] = '{17, -3, 88, -128, 127, 5, -60, 42, 0, -1, 99, -77,
                                        33, 120, -128, 64, -9, 2, -110, 71, 8, -45, 127, -20};
    localparam int STIM_GAP [N_STIM] = '{0, 0, 1, 0, 0, 0, 2, 0, 0, 1, 0, 0,
                                        0, 0, 3, 0, 0, 0, 1, 0, 0, 0, 0, 0};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [7:0] in_sample = '0;
    logic              cw_en = 1'b0;
    logic [3:0]        cw_addr = '0;
    logic signed [7:0] cw_data = '0;
    logic              ov_m, ov_p;
    logic signed [19:0] od_m, od_p;

    int checks = 0;
    int fails  = 0;
    int hist [0:511];
    int nacc = 0;
    int hm [9];
    int hp [9];
    longint last_m = 0;
    longint last_p = 0;

    always #2 clk = ~clk;

    poly_decim3_fir uut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_sample (in_sample),
        .cw_en (cw_en), .cw_addr (cw_addr), .cw_data (cw_data),
        .out_valid (ov_m), .out_data (od_m)
    );

    poly_decim3_fir #(.NTAPS (7)) uut_pad (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_sample (in_sample),
        .cw_en (cw_en), .cw_addr (cw_addr), .cw_data (cw_data),
        .out_valid (ov_p), .out_data (od_p)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int tri_coef(input int k, input int ntaps);
        int m;
        if (k >= ntaps) return 0;
        m = (k < ntaps - 1 - k) ? k : ntaps - 1 - k;
        return 8 * (m + 1);
    endfunction

    function automatic longint model(input bit pad, input int n);
        longint s = 0;
        for (int k = 0; k < 9; k++) begin
            if (n - k >= 0) s += longint'(pad ? hp[k] : hm[k]) * hist[n-k];
        end
        return s;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        cw_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        nacc = 0;
        for (int k = 0; k < 9; k++) begin
            hm[k] = tri_coef(k, 9);
            hp[k] = tri_coef(k, 7);
        end
        last_m = 0;
        last_p = 0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "out_valid after reset", ov_m, 0);
        check("R1", "out_data after reset", od_m, 0);
        check("R1", "pad out_valid after reset", ov_p, 0);
    endtask

    task automatic write_coef(input int a, input int v, input string req);
        cw_en = 1'b1;
        cw_addr = 4'(a);
        cw_data = 8'(v);
        @(posedge clk);
        @(negedge clk);
        cw_en = 1'b0;
        if (a < 9) hm[a] = int'($signed(8'(v)));
        if (a < 7) hp[a] = int'($signed(8'(v)));
        check(req, "no strobe during write", ov_m, 0);
    endtask

    // Accept one sample, then read the outputs one falling edge after the accepting edge
    task automatic push(input int v, input string req);
        int n;
        bit pulse;
        logic signed [7:0] v8;
        v8 = 8'(v);
        in_valid = 1'b1;
        in_sample = v8;
        hist[nacc] = int'(v8);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        n = nacc;
        nacc++;
        pulse = (n % 3 == 2) && (n >= 8);
        check((n < 9) ? "R3" : "R2", "out_valid", ov_m, pulse);
        check("R6", "pad out_valid", ov_p, pulse);
        if (pulse) begin
            check(req, "out_data", od_m, model(1'b0, n));
            check("R6", "pad out_data", od_p, model(1'b1, n));
            last_m = model(1'b0, n);
            last_p = model(1'b1, n);
        end else begin
            check("R8", "held out_data", od_m, last_m);
            check("R8", "pad held out_data", od_p, last_p);
        end
    endtask

    task automatic idle(input int cyc);
        repeat (cyc) begin
            @(posedge clk);
            @(negedge clk);
            check("R4", "no strobe when idle", ov_m, 0);
            check("R4", "pad no strobe when idle", ov_p, 0);
            check("R8", "out_data stable when idle", od_m, last_m);
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Default coefficients, table-driven stream with idle gaps (R2 R3 R4 R6 R8)
        for (int i = 0; i < N_STIM; i++) begin
            push(STIM_X[i], "R2");
            if (STIM_GAP[i] > 0) idle(STIM_GAP[i]);
        end

        // Coefficient writes, including addresses outside each instance's range (R5 R6)
        do_reset();
        write_coef(0, -5, "R5");
        write_coef(1, 12, "R5");
        write_coef(2, -33, "R5");
        write_coef(3, 70, "R5");
        write_coef(4, 127, "R5");
        write_coef(5, -128, "R5");
        write_coef(6, 3, "R5");
        write_coef(7, -1, "R6");
        write_coef(8, 45, "R6");
        write_coef(13, 99, "R5");
        for (int i = 0; i < N_STIM; i++) begin
            push(-STIM_X[i], "R5");
            if (STIM_GAP[N_STIM-1-i] > 0) idle(STIM_GAP[N_STIM-1-i]);
        end

        // Full-scale operands (R7)
        do_reset();
        for (int k = 0; k < 9; k++) write_coef(k, -128, "R7");
        for (int i = 0; i < 12; i++) push(-128, "R7");
        check("R7", "full-scale sum", last_m, 147456);
        for (int i = 0; i < 12; i++) push(127, "R7");

        // Reset in the middle of a period restarts counting and coefficients (R1 R3)
        do_reset();
        write_coef(4, 1, "R5");
        for (int i = 0; i < 5; i++) push(STIM_X[i], "R2");
        do_reset();
        for (int i = 0; i < 12; i++) push(STIM_X[i+5], "R3");
        idle(2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule